// File: doc/BRIEF.md
# Eight-Lane Double-Data-Rate Word Serializer

The block converts eight 12-bit sample words, one per channel, into eight serial data lines. A fast input clock runs at twelve times the sample rate, so each fast cycle carries exactly one data bit on every line. Each 12-cycle frame therefore carries one complete word per lane.

Two forwarded clocks travel with the data. The frame clock runs at the sample rate with a 50% duty cycle. Its rising edge coincides with the first bit of every word. The bit clock toggles on every fast cycle, so it runs at six times the frame rate and places one data bit on each of its edges.

A receiver captures data on both bit-clock edges and aligns words to the frame-clock rising edge. A runtime input selects whether words leave most-significant bit first or least-significant bit first.

Top module: `ddr_word_serializer`

## Requirements
- R1: While the synchronous reset `rst` is sampled high at a clock edge, that edge drives all serial data lines low, `bitClk` low and `frameClk` low.
- R2: The first clock edge with `rst` low captures all eight words and launches bit slot 0 of a frame. Every frame then lasts exactly 12 fast cycles, with one bit slot per cycle, and the next frame follows without a gap.
- R3: With `lsbFirst` = 0 at capture, bit slot k (0..11) of a lane carries bit 11-k of its captured word (MSB first).
- R4: With `lsbFirst` = 1 at capture, bit slot k of a lane carries bit k of its captured word (LSB first).
- R5: Words are sampled only at the edge that launches bit slot 0. Changing `sampleWords` later in the frame does not alter any bit of the frame in progress.
- R6: A change of `lsbFirst` during a frame has no effect on the frame in progress. It applies from the next frame on.
- R7: `frameClk` is high during bit slots 0..5 and low during slots 6..11. Its rising edge is launched together with slot 0, and `bitClk` is high at that moment.
- R8: `bitClk` toggles on every fast cycle after reset. It is high in even bit slots and low in odd ones, so a new bit appears on each of its edges.
- R9: Lane ch (0..7) serializes the word on `sampleWords[ch*12 +: 12]` onto `serData[ch]`, independently of the other lanes.
- R10: A reset asserted in the middle of a frame abandons that frame. After release, a fresh frame starts at bit slot 0 on the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twelve times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| lsbFirst | input | 1 | Bit order select: 1 sends the LSB first, 0 sends the MSB first |
| sampleWords | input | 96 | Eight 12-bit words; lane ch occupies bits ch*12 +: 12 |
| serData | output | 8 | One serial data line per lane |
| bitClk | output | 1 | Forwarded bit clock, data valid on both edges |
| frameClk | output | 1 | Forwarded frame clock at the sample rate |

## Verification
The same lane contents are sent once MSB-first and once LSB-first. Any mix-up of slot index and bit index therefore shows up as a wrong bit in some slot. Asymmetric words (a lone top bit, a lone low bit, distinct nibbles per lane) separate a lane swap or a reversed word from correct output. The all-zero and all-one frames expose stuck lines.

In every table frame, both the words and the bit order are inverted right after capture. This distinguishes a design that latches at the frame boundary from one that follows its inputs mid-frame. A reset in the middle of a frame, followed by a fresh frame, tells a counter that restarts at zero from one that resumes.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;

  // Strobes sent from the sequencing control to the lane datapath.
  typedef struct packed {
    logic load;   // capture new words, launch bit slot 0
    logic shift;  // advance every lane by one bit slot
  } serStrobes_t;

endpackage

// File: rtl/dws_control.sv
module dws_control
  import ddr_ser_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic        clk,
  input  logic        rst,
  output serStrobes_t strobes,
  output logic        bitClk,
  output logic        frameClk
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam int LAST  = WORD_W - 1;
  localparam int HALF  = WORD_W / 2;

  // slotCnt holds the index of the bit slot launched at the next edge.
  logic [CNT_W-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt  <= '0;
      bitClk   <= 1'b0;
      frameClk <= 1'b0;
    end else begin
      slotCnt  <= (slotCnt == CNT_W'(LAST)) ? '0 : slotCnt + 1'b1;
      bitClk   <= ~bitClk;
      frameClk <= (slotCnt < CNT_W'(HALF));
    end
  end

  always_comb begin
    strobes.load  = !rst && (slotCnt == '0);
    strobes.shift = !rst && (slotCnt != '0);
  end

endmodule

// File: rtl/dws_datapath.sv
module dws_datapath
  import ddr_ser_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  serStrobes_t              strobes,
  input  logic                     lsbFirst,
  input  logic [NUM_CH*WORD_W-1:0] sampleWords,
  output logic [NUM_CH-1:0]        serData
);

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_lane
      logic [WORD_W-1:0] inWord;
      logic [WORD_W-1:0] oriented;
      logic [WORD_W-1:0] shiftReg;

      assign inWord = sampleWords[ch*WORD_W +: WORD_W];

      // The bit to leave first is placed at the top, so every lane shifts one way.
      always_comb begin
        for (int b = 0; b < WORD_W; b++) begin
          oriented[b] = lsbFirst ? inWord[WORD_W-1-b] : inWord[b];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          shiftReg <= '0;
        end else if (strobes.load) begin
          shiftReg <= oriented;
        end else if (strobes.shift) begin
          shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        end
      end

      assign serData[ch] = shiftReg[WORD_W-1];
    end
  endgenerate

endmodule

// File: rtl/ddr_word_serializer.sv
module ddr_word_serializer
  import ddr_ser_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lsbFirst,
  input  logic [NUM_CH*WORD_W-1:0] sampleWords,
  output logic [NUM_CH-1:0]        serData,
  output logic                     bitClk,
  output logic                     frameClk
);

  serStrobes_t strobes;

  dws_control #(.WORD_W(WORD_W)) u_control (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .bitClk   (bitClk),
    .frameClk (frameClk)
  );

  dws_datapath #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .lsbFirst    (lsbFirst),
    .sampleWords (sampleWords),
    .serData     (serData)
  );

endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] serData,
  input logic              bitClk,
  input logic              frameClk
);

  localparam int HALF  = WORD_W / 2;
  localparam int RUN_W = $clog2(WORD_W) + 1;

  logic             live;
  logic [RUN_W-1:0] hiRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      live  <= 1'b0;
      hiRun <= '0;
    end else begin
      live  <= 1'b1;
      hiRun <= frameClk ? hiRun + 1'b1 : '0;
    end
  end

  // R1: reset drives every output low
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (serData == '0 && !bitClk && !frameClk));

  // R8: bit clock toggles on every fast cycle after reset
  p_bitclk_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    live |-> (bitClk != $past(bitClk)));

  // R7: frame clock rises with the bit clock high
  p_frame_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(frameClk) |-> bitClk);

  // R7: frame clock stays high for exactly half a frame
  p_frame_high_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(frameClk) |-> (hiRun == RUN_W'(HALF)));

  // R7: never longer than half a frame high
  p_frame_high_max_r7: assert property (@(posedge clk) disable iff (rst)
    hiRun <= RUN_W'(HALF));

endmodule

bind ddr_word_serializer dws_checker #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .serData  (serData),
  .bitClk   (bitClk),
  .frameClk (frameClk)
);

// File: tb/ddr_word_serializer_bench.sv
`timescale 1ns/1ps
module ddr_word_serializer_bench;

  localparam int NUM_CH = 8;
  localparam int WORD_W = 12;
  localparam int BUS_W  = NUM_CH * WORD_W;
  localparam int HALF   = WORD_W / 2;
  localparam int NVEC   = 6;

  // bit 96 = lsbFirst, bits 95:0 = eight words, lane 7 at the top
  localparam logic [BUS_W:0] VEC [0:NVEC-1] = '{
    {1'b0, 96'h800_001_A5A_5A5_123_456_789_ABC},
    {1'b1, 96'h800_001_A5A_5A5_123_456_789_ABC},
    {1'b0, 96'hFFF_000_FFF_000_C3C_3C3_F0F_0F0},
    {1'b1, 96'h001_800_0F0_F0F_6A9_956_3E1_1C7},
    {1'b0, 96'h000_000_000_000_000_000_000_000},
    {1'b1, 96'hFFF_FFF_FFF_FFF_FFF_FFF_FFF_FFF}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lsbFirst = 1'b0;
  logic [BUS_W-1:0]  sampleWords = '0;
  logic [NUM_CH-1:0] serData;
  logic              bitClk;
  logic              frameClk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_word_serializer #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_ddr_word_serializer (
    .clk         (clk),
    .rst         (rst),
    .lsbFirst    (lsbFirst),
    .sampleWords (sampleWords),
    .serData     (serData),
    .bitClk      (bitClk),
    .frameClk    (frameClk)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NUM_CH-1:0] expBits(input logic [BUS_W-1:0] w,
                                                 input logic lsb, input int k);
    logic [NUM_CH-1:0] r;
    for (int c = 0; c < NUM_CH; c++) begin
      r[c] = w[c*WORD_W + (lsb ? k : WORD_W-1-k)];
    end
    return r;
  endfunction

  // Called at a negedge just before a capture edge (R2, R9).
  task automatic runFrame(input logic [BUS_W-1:0] w, input logic lsb,
                          input bit scramble, input string dataReq);
    sampleWords = w;
    lsbFirst    = lsb;
    for (int k = 0; k < WORD_W; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(serData == expBits(w, lsb, k), dataReq, $sformatf("lanes slot %0d", k),
            32'(serData), 32'(expBits(w, lsb, k)));
      check(frameClk == (k < HALF), "R7", $sformatf("frameClk slot %0d", k),
            32'(frameClk), 32'(k < HALF));
      check(bitClk == (k % 2 == 0), "R8", $sformatf("bitClk slot %0d", k),
            32'(bitClk), 32'(k % 2 == 0));
      if (k == 0 && scramble) begin
        // R5 and R6: mid-frame input changes must not reach this frame
        sampleWords = ~w;
        lsbFirst    = ~lsb;
      end
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(serData == '0, "R1", "data in reset", 32'(serData), 32'h0);
    check(!bitClk, "R1", "bitClk in reset", 32'(bitClk), 32'h0);
    check(!frameClk, "R1", "frameClk in reset", 32'(frameClk), 32'h0);

    rst = 1'b0;
    // R2/R3/R4/R5/R6/R9: table walk, inputs inverted right after capture
    for (int v = 0; v < NVEC; v++) begin
      runFrame(VEC[v][BUS_W-1:0], VEC[v][BUS_W], 1'b1,
               VEC[v][BUS_W] ? "R4" : "R3");
    end

    // R10: reset in the middle of a frame
    sampleWords = 96'h123_456_789_ABC_DEF_024_681_357;
    lsbFirst    = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(serData == '0 && !bitClk && !frameClk, "R1", "outputs after mid-frame reset",
            {bitClk, frameClk, 22'h0, serData}, 32'h0);
    end
    rst = 1'b0;
    runFrame(96'hF00_0F0_00F_E01_D02_C03_B04_A05, 1'b1, 1'b0, "R10");
    // R2: back-to-back frame with no gap, R9 one lane set
    runFrame(96'h000_000_000_000_000_800_000_000, 1'b0, 1'b0, "R9");

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule